// File: doc/BRIEF.md
# Memory Access Watchpoint Unit

This block watches the stream of accesses that reach a memory arbiter and flags accesses that fall inside programmed windows. It holds four independent watchpoints. Each one is given an inclusive address window, a mask of access kinds and a mask of requesting clients. An access that satisfies all three sets that watchpoint's hit flag and records what the access looked like, so software can later work out who touched the region and how.

Each hit flag is sticky. Software clears it with two writes. The first write goes to the watchpoint's own acknowledge register and arms the clear. The second goes to a shared acknowledge register that has one bit per watchpoint. A per-watchpoint enable mask selects which hit flags drive the single interrupt line. A masked view and a raw view of the hit flags can both be read back.

Register map, word addressed, 6-bit address. With bit 5 clear, bits 4:3 select the watchpoint and bits 2:0 select the offset:

- offset 0: window low bound (read/write)
- offset 1: window high bound (read/write)
- offset 2: kind mask (read/write)
- offset 3: client mask (read/write)
- offset 4: captured client set (read)
- offset 5: captured address (read)
- offset 6: captured first-hit details (read)
- offset 7: flags on read, local acknowledge on write

With bit 5 set, bits 1:0 select a shared register:

- 0: interrupt enable mask (read/write)
- 1: masked hit flags (read)
- 2: shared acknowledge (write)
- 3: raw hit flags (read)

Top module: `mawp_top`

## Requirements
- R1: The low bound, high bound, kind mask and client mask of every watchpoint, and the shared enable mask, read back the last value written to them.
- R2: The raw hit flag of a watchpoint (bit i of shared register 3) is set after the clock edge at which a valid access arrives that meets all of these conditions: low ≤ address ≤ high, bit `client` of its client mask is set, and bit `kind` of its kind mask is set. The access kinds are 0 read, 1 write, 2 fetch and 3 atomic. Several watchpoints can be set by the same access.
- R3: An access that misses the window, or whose client bit or kind bit is clear, or whose client index is at or above the client count (14), leaves the hit flags unchanged.
- R4: On the hit that sets a clear flag, the unit records the address (offset 5) and the first-hit details (offset 6, packed as size in bits 2:0, kind in bits 4:3 and client in bits 8:5). These values then stay frozen until the flag is cleared.
- R5: The captured client set (offset 4) is loaded with the one-hot client of the first hit. Every later hit before the clear ORs in the hitting client.
- R6: A hit flag is cleared only when two writes happen in order. First, offset 7 of that watchpoint is written while the flag is set, which raises the armed bit (bit 1 of offset 7, with the hit flag in bit 0). Then the shared acknowledge register is written with that watchpoint's bit set. A shared acknowledge that is not armed has no effect. A local acknowledge written while the flag is clear does not arm.
- R7: Shared register 1 reads as the raw hit flags ANDed with the enable mask.
- R8: The interrupt output equals the OR of the masked hit flags as they stood one clock earlier.
- R9: After reset, all configuration, capture, flag, mask and read-data registers are zero and the interrupt is low.
- R10: Read data shows the register addressed at the previous clock edge, with the state from before that edge.
- R11: When a clearing acknowledge and a matching access fall on the same edge, the flag stays set and the capture restarts from the new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_valid | input | 1 | An access is present on the monitor bus |
| mon_client | input | 4 | Index of the requesting client |
| mon_addr | input | 32 | Access address |
| mon_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 atomic |
| mon_size | input | 3 | Access size code |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, OR of the enabled hit flags |

## Verification
An access or a register write changes the flags and the captures at the clock edge where it is presented. A read placed on the port at one edge returns its data after the next edge. The interrupt follows the masked flags one edge later. The bench reference model applies these same latencies: at every rising edge it computes the read word and the interrupt from its state before the update. The bench compares both against the design at the next falling edge. The directed reads give the flags at least one settling cycle after each stimulus before sampling them.

// File: rtl/mawp_pkg.sv
package mawp_pkg;
  localparam int KIND_W = 2;
  localparam int KINDS  = 1 << KIND_W;

  typedef enum logic [KIND_W-1:0] {
    KIND_READ   = 2'd0,
    KIND_WRITE  = 2'd1,
    KIND_FETCH  = 2'd2,
    KIND_ATOMIC = 2'd3
  } acc_kind_e;

  localparam logic [2:0] OFF_LO    = 3'd0;
  localparam logic [2:0] OFF_HI    = 3'd1;
  localparam logic [2:0] OFF_KMASK = 3'd2;
  localparam logic [2:0] OFF_CMASK = 3'd3;
  localparam logic [2:0] OFF_CSET  = 3'd4;
  localparam logic [2:0] OFF_CADDR = 3'd5;
  localparam logic [2:0] OFF_CINFO = 3'd6;
  localparam logic [2:0] OFF_ACK   = 3'd7;

  localparam logic [1:0] G_ENABLE = 2'd0;
  localparam logic [1:0] G_MASKED = 2'd1;
  localparam logic [1:0] G_ACK    = 2'd2;
  localparam logic [1:0] G_RAW    = 2'd3;
endpackage

// File: rtl/mawp_match.sv
module mawp_match #(
  parameter int ADDR_W      = 32,
  parameter int NUM_CLIENTS = 14,
  parameter int CID_W       = 4
) (
  input  logic                         valid,
  input  logic [CID_W-1:0]             client,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [mawp_pkg::KIND_W-1:0]  kind,
  input  logic [ADDR_W-1:0]            lo,
  input  logic [ADDR_W-1:0]            hi,
  input  logic [mawp_pkg::KINDS-1:0]   kmask,
  input  logic [NUM_CLIENTS-1:0]       cmask,
  output logic                         hit
);
  localparam int CEXT = 1 << CID_W;

  logic [CEXT-1:0] cmask_ext;
  logic            in_win;

  assign cmask_ext = CEXT'(cmask);
  assign in_win    = (addr >= lo) && (addr <= hi);
  assign hit       = valid && in_win && cmask_ext[client] && kmask[kind];
endmodule

// File: rtl/mawp_unit.sv
module mawp_unit
  import mawp_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_CLIENTS = 14,
  parameter int CID_W       = 4,
  parameter int SIZE_W      = 3,
  parameter int DATA_W      = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [2:0]             wr_off,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   gack,
  input  logic                   mon_valid,
  input  logic [CID_W-1:0]       mon_client,
  input  logic [ADDR_W-1:0]      mon_addr,
  input  logic [KIND_W-1:0]      mon_kind,
  input  logic [SIZE_W-1:0]      mon_size,
  input  logic [2:0]             rd_off,
  output logic [DATA_W-1:0]      rd_word,
  output logic                   flag
);
  localparam int INFO_W = SIZE_W + KIND_W + CID_W;

  logic [ADDR_W-1:0]      lo_q, hi_q, caddr_q;
  logic [KINDS-1:0]       kmask_q;
  logic [NUM_CLIENTS-1:0] cmask_q, cset_q, onehot;
  logic [INFO_W-1:0]      cinfo_q;
  logic                   flag_q, armed_q;
  logic                   hit, clr, busy;

  mawp_match #(
    .ADDR_W(ADDR_W), .NUM_CLIENTS(NUM_CLIENTS), .CID_W(CID_W)
  ) u_match (
    .valid(mon_valid), .client(mon_client), .addr(mon_addr), .kind(mon_kind),
    .lo(lo_q), .hi(hi_q), .kmask(kmask_q), .cmask(cmask_q), .hit(hit)
  );

  assign onehot = NUM_CLIENTS'(1) << mon_client;
  assign clr    = gack && armed_q;
  assign busy   = flag_q && !clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0; hi_q <= '0; kmask_q <= '0; cmask_q <= '0;
      caddr_q <= '0; cset_q <= '0; cinfo_q <= '0;
      flag_q <= 1'b0; armed_q <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_off)
          OFF_LO:    lo_q    <= wdata[ADDR_W-1:0];
          OFF_HI:    hi_q    <= wdata[ADDR_W-1:0];
          OFF_KMASK: kmask_q <= wdata[KINDS-1:0];
          OFF_CMASK: cmask_q <= wdata[NUM_CLIENTS-1:0];
          OFF_ACK:   if (busy) armed_q <= 1'b1;
          default:   ;
        endcase
      end
      if (clr) begin
        flag_q  <= 1'b0;
        armed_q <= 1'b0;
      end
      if (hit) begin
        if (!busy) begin
          flag_q  <= 1'b1;
          caddr_q <= mon_addr;
          cset_q  <= onehot;
          cinfo_q <= {mon_client, mon_kind, mon_size};
        end else begin
          cset_q  <= cset_q | onehot;
        end
      end
    end
  end

  always_comb begin
    case (rd_off)
      OFF_LO:    rd_word = DATA_W'(lo_q);
      OFF_HI:    rd_word = DATA_W'(hi_q);
      OFF_KMASK: rd_word = DATA_W'(kmask_q);
      OFF_CMASK: rd_word = DATA_W'(cmask_q);
      OFF_CSET:  rd_word = DATA_W'(cset_q);
      OFF_CADDR: rd_word = DATA_W'(caddr_q);
      OFF_CINFO: rd_word = DATA_W'(cinfo_q);
      default:   rd_word = DATA_W'({armed_q, flag_q});
    endcase
  end

  assign flag = flag_q;

  // R2
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag_q);

  // R6
  clear_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(gack && armed_q));

  // R6
  arm_only_when_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> $past(flag_q));

  // R4
  capture_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && $past(flag_q) && !$past(gack && armed_q))
      |-> ($stable(caddr_q) && $stable(cinfo_q)));

  // R5
  client_set_grows_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && $past(flag_q) && !$past(gack && armed_q))
      |-> ((cset_q & $past(cset_q)) == $past(cset_q)));
endmodule

// File: rtl/mawp_top.sv
module mawp_top
  import mawp_pkg::*;
#(
  parameter int NUM_WP      = 4,
  parameter int ADDR_W      = 32,
  parameter int NUM_CLIENTS = 14,
  parameter int CID_W       = 4,
  parameter int SIZE_W      = 3,
  parameter int DATA_W      = 32,
  parameter int REG_AW      = 3 + $clog2(NUM_WP) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mon_valid,
  input  logic [CID_W-1:0]  mon_client,
  input  logic [ADDR_W-1:0] mon_addr,
  input  logic [KIND_W-1:0] mon_kind,
  input  logic [SIZE_W-1:0] mon_size,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int UIDX_W = $clog2(NUM_WP);

  logic              gsel;
  logic [UIDX_W-1:0] uidx;
  logic [2:0]        uoff;
  logic [1:0]        goff;
  logic [NUM_WP-1:0] flags, enable_q, gack;
  logic [DATA_W-1:0] unit_rd [NUM_WP];
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] rdata_q;
  logic              irq_q;

  assign gsel = reg_addr[REG_AW-1];
  assign uidx = reg_addr[3 +: UIDX_W];
  assign uoff = reg_addr[2:0];
  assign goff = reg_addr[1:0];

  for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
    assign gack[i] = reg_we && gsel && (goff == G_ACK) && reg_wdata[i];

    mawp_unit #(
      .ADDR_W(ADDR_W), .NUM_CLIENTS(NUM_CLIENTS), .CID_W(CID_W),
      .SIZE_W(SIZE_W), .DATA_W(DATA_W)
    ) u_unit (
      .clk(clk), .rst(rst),
      .wr_en(reg_we && !gsel && (uidx == UIDX_W'(i))),
      .wr_off(uoff), .wdata(reg_wdata), .gack(gack[i]),
      .mon_valid(mon_valid), .mon_client(mon_client), .mon_addr(mon_addr),
      .mon_kind(mon_kind), .mon_size(mon_size),
      .rd_off(uoff), .rd_word(unit_rd[i]), .flag(flags[i])
    );
  end

  always_comb begin
    if (gsel) begin
      case (goff)
        G_ENABLE: rd_next = DATA_W'(enable_q);
        G_MASKED: rd_next = DATA_W'(flags & enable_q);
        G_RAW:    rd_next = DATA_W'(flags);
        default:  rd_next = '0;
      endcase
    end else begin
      rd_next = unit_rd[uidx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      rdata_q  <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (reg_we && gsel && (goff == G_ENABLE)) enable_q <= reg_wdata[NUM_WP-1:0];
      rdata_q <= rd_next;
      irq_q   <= |(flags & enable_q);
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = irq_q;

  // R8
  irq_follows_flags_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == $past(|(flags & enable_q)));

  // R6
  flag_clear_source_chk: assert property (@(posedge clk) disable iff (rst)
    (|($past(flags) & ~flags)) |-> $past(reg_we && gsel && (goff == G_ACK)));
endmodule

// File: tb/mawp_top_tb.sv
module mawp_top_tb;
  localparam int NW = 4;
  localparam int NC = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mon_valid = 1'b0;
  logic [3:0]  mon_client = '0;
  logic [31:0] mon_addr = '0;
  logic [1:0]  mon_kind = '0;
  logic [2:0]  mon_size = '0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mawp_top u_dut (
    .clk(clk), .rst(rst), .mon_valid(mon_valid), .mon_client(mon_client),
    .mon_addr(mon_addr), .mon_kind(mon_kind), .mon_size(mon_size),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // behavioural reference model
  longint m_lo[NW], m_hi[NW], m_caddr[NW];
  int     m_km[NW], m_cm[NW], m_cset[NW], m_cinfo[NW];
  bit     m_flag[NW], m_arm[NW];
  int     m_en;
  longint exp_rdata;
  bit     exp_irq;
  int     last_addr;

  function automatic longint model_read(int a);
    int u;
    int fl;
    fl = 0;
    for (int i = 0; i < NW; i++) if (m_flag[i]) fl |= (1 << i);
    if (a >= 32) begin
      case (a & 3)
        0: return m_en;
        1: return fl & m_en;
        3: return fl;
        default: return 0;
      endcase
    end
    u = (a >> 3) & 3;
    case (a & 7)
      0: return m_lo[u];
      1: return m_hi[u];
      2: return m_km[u];
      3: return m_cm[u];
      4: return m_cset[u];
      5: return m_caddr[u];
      6: return m_cinfo[u];
      default: return (int'(m_arm[u]) << 1) | int'(m_flag[u]);
    endcase
  endfunction

  function automatic string tag_of(int a);
    if (a >= 32) return ((a & 3) == 0) ? "R1" : (((a & 3) == 1) ? "R7" : "R2");
    case (a & 7)
      0, 1, 2, 3: return "R1";
      4: return "R5";
      5, 6: return "R4";
      default: return "R6";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) begin
        m_lo[i] = 0; m_hi[i] = 0; m_caddr[i] = 0; m_km[i] = 0; m_cm[i] = 0;
        m_cset[i] = 0; m_cinfo[i] = 0; m_flag[i] = 0; m_arm[i] = 0;
      end
      m_en = 0; exp_rdata = 0; exp_irq = 0; last_addr = 0;
    end else begin
      bit hit, clr, busy, anyf;
      int a;
      a = int'(reg_addr);
      exp_rdata = model_read(a);
      last_addr = a;
      anyf = 0;
      for (int i = 0; i < NW; i++) if (m_flag[i] && m_en[i]) anyf = 1;
      exp_irq = anyf;
      for (int i = 0; i < NW; i++) begin
        hit = mon_valid && (mon_client < NC) && m_cm[i][mon_client] &&
              m_km[i][mon_kind] && (longint'(mon_addr) >= m_lo[i]) &&
              (longint'(mon_addr) <= m_hi[i]);
        clr = reg_we && (a >= 32) && ((a & 3) == 2) && reg_wdata[i] && m_arm[i];
        busy = m_flag[i] && !clr;
        if (reg_we && a < 32 && ((a >> 3) & 3) == i) begin
          case (a & 7)
            0: m_lo[i] = reg_wdata;
            1: m_hi[i] = reg_wdata;
            2: m_km[i] = reg_wdata & 15;
            3: m_cm[i] = reg_wdata & ((1 << NC) - 1);
            7: if (busy) m_arm[i] = 1;
            default: ;
          endcase
        end
        if (clr) begin m_flag[i] = 0; m_arm[i] = 0; end
        if (hit) begin
          if (!busy) begin
            m_flag[i] = 1; m_caddr[i] = mon_addr; m_cset[i] = 1 << mon_client;
            m_cinfo[i] = (int'(mon_client) << 5) | (int'(mon_kind) << 3) | int'(mon_size);
          end else begin
            m_cset[i] |= (1 << mon_client);
          end
        end
      end
      if (reg_we && a >= 32 && (a & 3) == 0) m_en = reg_wdata & 15;
    end
  end

  // per-cycle comparison, away from the active edge (R10 latency built into the model)
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (longint'(reg_rdata) != exp_rdata) begin
        errors++;
        $display("FAIL %s rdata addr %0d: got %h exp %h", tag_of(last_addr), last_addr,
                 reg_rdata, exp_rdata);
      end
      checks++;
      if (irq != exp_irq) begin
        errors++;
        $display("FAIL R8 irq: got %0d exp %0d", irq, exp_irq);
      end
    end
  end

  task automatic check(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic acc(int c, int ad, int k, int s);
    @(negedge clk);
    mon_valid = 1; mon_client = 4'(c); mon_addr = ad; mon_kind = 2'(k); mon_size = 3'(s);
    @(negedge clk);
    mon_valid = 0;
  endtask

  task automatic wr_acc(int a, int d, int c, int ad, int k, int s);
    @(negedge clk);
    reg_we = 1; reg_addr = 6'(a); reg_wdata = d;
    mon_valid = 1; mon_client = 4'(c); mon_addr = ad; mon_kind = 2'(k); mon_size = 3'(s);
    @(negedge clk);
    reg_we = 0; mon_valid = 0;
  endtask

  task automatic rd_check(int a, longint exp, string tag);
    @(negedge clk);
    reg_addr = 6'(a);
    @(negedge clk);
    check(tag, reg_rdata, exp);
  endtask

  task automatic irq_check(bit exp, string tag);
    @(negedge clk);
    @(negedge clk);
    check(tag, irq, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R9 reset state
    check("R9", reg_rdata, 0);
    check("R9", irq, 0);
    rd_check(6'h00, 0, "R9");
    rd_check(6'h23, 0, "R9");
    // R1 configuration
    wr(6'h00, 32'h100); wr(6'h01, 32'h1FF); wr(6'h02, 2); wr(6'h03, (1 << 3) | (1 << 5));
    wr(6'h20, 1);
    rd_check(6'h01, 32'h1FF, "R1");
    rd_check(6'h03, 32'h28, "R1");
    rd_check(6'h20, 1, "R1");
    // R3 misses
    acc(3, 32'hFF, 1, 0);
    acc(3, 32'h200, 1, 0);
    acc(4, 32'h150, 1, 0);
    acc(3, 32'h150, 0, 0);
    acc(15, 32'h150, 1, 0);
    rd_check(6'h23, 0, "R3");
    // R2 / R4 first hit at high bound
    acc(5, 32'h1FF, 1, 2);
    rd_check(6'h23, 1, "R2");
    rd_check(6'h06, (5 << 5) | (1 << 3) | 2, "R4");
    irq_check(1, "R8");
    // R5 accumulation, R4 freeze, low bound inclusive
    acc(3, 32'h100, 1, 1);
    rd_check(6'h05, 32'h1FF, "R4");
    rd_check(6'h04, 32'h28, "R5");
    // R6 clearing order
    wr(6'h22, 1);
    rd_check(6'h23, 1, "R6");
    wr(6'h07, 0);
    rd_check(6'h07, 3, "R6");
    wr(6'h22, 1);
    rd_check(6'h23, 0, "R6");
    irq_check(0, "R8");
    wr(6'h07, 0);
    rd_check(6'h07, 0, "R6");
    // R7 masking
    wr(6'h08, 0); wr(6'h09, 32'hFFFF); wr(6'h0A, 15); wr(6'h0B, 32'h3FFF);
    acc(2, 32'h40, 0, 3);
    rd_check(6'h23, 2, "R7");
    rd_check(6'h21, 0, "R7");
    irq_check(0, "R7");
    wr(6'h20, 3);
    rd_check(6'h21, 2, "R7");
    irq_check(1, "R8");
    // R11 clear and hit on the same edge
    wr(6'h0F, 0);
    wr_acc(6'h22, 2, 7, 32'h80, 2, 1);
    rd_check(6'h23, 2, "R11");
    rd_check(6'h0D, 32'h80, "R11");
    rd_check(6'h0C, 1 << 7, "R11");
    rd_check(6'h0F, 1, "R11");
    // R2 two watchpoints on one access
    wr(6'h0F, 0);
    wr(6'h22, 2);
    acc(5, 32'h180, 1, 0);
    rd_check(6'h23, 3, "R2");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule